// File: doc/BRIEF.md
# Twelve-Hour Timekeeping Core

This block keeps the time of day as hours, minutes and seconds, with hours running 1 through 12. It runs in the fast oscillator clock domain. A 1024 Hz time base sets its pace. The time base is either a divided-down oscillator count or the rising edges of an external 1024 Hz signal, chosen by a select input. The chosen base is driven back out as a square wave. A 1 Hz square wave with 50% duty drives the colon of the display.

Three push-button inputs set the clock. The minute and hour buttons each pass through a logic debouncer. Each gives one step per press, then steps again at a faster rate while the button is held. The correction button rounds the time to the nearest whole minute. An active-low blanking input locks out all three buttons, while timekeeping carries on. The time comes out as BCD digits ready for a segment decoder.

Top module: `twelve_hour_clock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state becomes 12:00 with seconds at zero and the sub-second count at zero. The outputs then read `hr_tens`=1, `hr_units`=2, `min_tens`=0, `min_units`=0 and `one_hz`=1.
- R2: With `ext_sel`=0, the clock advances `OSC_DIV` clocks per base tick and one second per `TICKS_PER_SEC` base ticks. `base_out` is 1 while the divider count is at least `OSC_DIV`/2.
- R3: With `ext_sel`=1, each rising edge of `ext_clk`, after a two-flop synchronizer, is one base tick. `base_out` equals `ext_clk` as sampled two clock edges earlier.
- R4: Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours go from 11 to 12 and from 12 to 1. The outputs are BCD: `hr_tens` is 1 only for hours 10 to 12, and `min_tens` ranges 0 to 5.
- R5: `one_hz` is 1 for the first `TICKS_PER_SEC`/2 base ticks of each second and 0 for the rest.
- R6: A minute step adds one to the minutes modulo 60. It never carries into hours and it clears the seconds.
- R7: An hour step advances the hours from 1 to 12 and then back to 1. It leaves the minutes unchanged.
- R8: A button level must hold for `DEBOUNCE_TICKS` consecutive base ticks before it is accepted. A press that spans fewer ticks has no effect.
- R9: A held minute or hour button steps once when accepted. It steps again after `TICKS_PER_SEC` base ticks (1 s), and then every `TICKS_PER_SEC`/2 ticks (2 Hz) until it is released.
- R10: A correction with seconds below 30 clears the seconds and leaves the minutes and hours unchanged.
- R11: A correction with seconds at 30 or more clears the seconds and adds one minute, carrying into hours (11:59 becomes 12:00).
- R12: While `blank_n` is 0, the minute, hour and correction buttons have no effect on the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low clear, used as power-on reset |
| ext_sel | input | 1 | 1 selects the external time base, 0 the divided oscillator |
| ext_clk | input | 1 | External 1024 Hz time base, asynchronous |
| blank_n | input | 1 | Active-low blanking; when 0 it locks out the buttons |
| hour_btn | input | 1 | Hour-advance button, raw level |
| min_btn | input | 1 | Minute-advance button, raw level |
| corr_btn | input | 1 | Round-to-nearest-minute button, raw level |
| hr_tens | output | 1 | Hours tens digit (0 or 1) |
| hr_units | output | 4 | Hours units digit, BCD |
| min_tens | output | 3 | Minutes tens digit, BCD |
| min_units | output | 4 | Minutes units digit, BCD |
| one_hz | output | 1 | 1 Hz square wave for the colon |
| base_out | output | 1 | Selected 1024 Hz time base as a square wave |

## Verification
A wrong hour or minute register shows on the BCD outputs on the next clock edge. The sub-second counter is just as direct, since it drives `one_hz` and the seconds carry. The seconds register is not visible at the ports. A fault there shows up only as a minute carry at the wrong moment, up to 60 s later. For this reason the correction and minute-step checks wait long enough for a wrong seconds value to show as an early or missing minute change. A wrong debouncer or repeat counter shows as a missing step, an extra step or a wrong gap between steps, within a few base ticks of the button changing.

// File: rtl/clock_pkg.sv
// Package: shared time types and increment helpers for the 12-hour clock.
// Assumes hours are held in binary 1..12 and minutes/seconds in binary 0..59.
package clock_pkg;

    typedef logic [3:0] hour_t;
    typedef logic [5:0] sixty_t;

    // Next hour value in the 1..12 cycle.
    function automatic hour_t hour_next(input hour_t h);
        return (h == 4'd12) ? 4'd1 : h + 4'd1;
    endfunction

    // Next value of a modulo-60 field.
    function automatic sixty_t sixty_next(input sixty_t v);
        return (v == 6'd59) ? 6'd0 : v + 6'd1;
    endfunction

endpackage

// File: rtl/clock_timebase.sv
// Module: produces the base tick (crystal divider or synchronized external
// edge), the base square wave, the once-per-second pulse and the 1 Hz wave.
// Assumes ext_clk is asynchronous and much slower than clk.
module clock_timebase #(
    parameter int DIV = 4096,
    parameter int TPS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic ext_clk,
    output logic base_tick,
    output logic base_level,
    output logic sec_tick,
    output logic one_hz
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int TW = (TPS > 1) ? $clog2(TPS) : 1;

    logic [DW-1:0] div_q;
    logic [TW-1:0] sub_q;
    logic [2:0]    ext_sh;
    logic          div_wrap;
    logic          ext_rise;

    // Free-running oscillator divider.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (div_wrap) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    // Two-flop synchronizer plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sh <= '0;
        else        ext_sh <= {ext_sh[1:0], ext_clk};
    end

    // Base-tick selection and square-wave output.
    always_comb begin
        div_wrap   = (div_q == DW'(DIV - 1));
        ext_rise   = ext_sh[1] & ~ext_sh[2];
        base_tick  = ext_sel ? ext_rise  : div_wrap;
        base_level = ext_sel ? ext_sh[1] : (div_q >= DW'(DIV / 2));
    end

    // Sub-second tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) sub_q <= '0;
        else if (base_tick) sub_q <= (sub_q == TW'(TPS - 1)) ? '0 : sub_q + 1'b1;
    end

    // Second pulse and 50% duty colon wave.
    always_comb begin
        sec_tick = base_tick && (sub_q == TW'(TPS - 1));
        one_hz   = (sub_q < TW'(TPS / 2));
    end

endmodule

// File: rtl/clock_button.sv
// Module: debounces one raw button on base ticks and emits one-cycle step
// pulses: one on acceptance, plus an optional hold-to-repeat stream.
// Assumes tick is a one-cycle pulse; DEB >= 1, HOLD > REP >= 1.
module clock_button #(
    parameter int DEB       = 20,
    parameter int HOLD      = 1024,
    parameter int REP       = 512,
    parameter int REPEAT_EN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic step
);
    localparam int DBW = $clog2(DEB + 1);

    logic [1:0]     sync_q;
    logic           stable_q;
    logic [DBW-1:0] dcnt_q;
    logic           press_q;
    logic           rep_q;

    // Bring the raw level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], raw};
    end

    // Accept a level after DEB consecutive differing ticks; pulse on press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            dcnt_q   <= '0;
            press_q  <= 1'b0;
        end else begin
            press_q <= 1'b0;
            if (tick) begin
                if (sync_q[1] != stable_q) begin
                    if (dcnt_q == DBW'(DEB - 1)) begin
                        stable_q <= sync_q[1];
                        dcnt_q   <= '0;
                        press_q  <= sync_q[1];
                    end else begin
                        dcnt_q <= dcnt_q + 1'b1;
                    end
                end else begin
                    dcnt_q <= '0;
                end
            end
        end
    end

    generate
        if (REPEAT_EN != 0) begin : g_repeat
            localparam int HW = $clog2(HOLD + 1);
            logic [HW-1:0] hcnt_q;

            // Hold timer: first repeat after HOLD ticks, then every REP ticks.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hcnt_q <= '0;
                    rep_q  <= 1'b0;
                end else begin
                    rep_q <= 1'b0;
                    if (!stable_q) begin
                        hcnt_q <= '0;
                    end else if (tick) begin
                        if (hcnt_q == HW'(HOLD - 1)) begin
                            rep_q  <= 1'b1;
                            hcnt_q <= HW'(HOLD - REP);
                        end else begin
                            hcnt_q <= hcnt_q + 1'b1;
                        end
                    end
                end
            end
        end else begin : g_single
            assign rep_q = 1'b0;
        end
    endgenerate

    assign step = press_q | rep_q;

endmodule

// File: rtl/clock_counter.sv
// Module: holds hours (1..12), minutes and seconds and applies, by priority,
// correction, minute step, hour step, then the second tick.
// Assumes step inputs are one-cycle pulses; blank_n gates all three.
module clock_counter
    import clock_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sec_tick,
    input  logic   blank_n,
    input  logic   corr_step,
    input  logic   min_step,
    input  logic   hr_step,
    output hour_t  hours,
    output sixty_t minutes,
    output sixty_t seconds
);

    // Time registers with button priority over the running count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hours   <= 4'd12;
            minutes <= 6'd0;
            seconds <= 6'd0;
        end else if (blank_n && corr_step) begin
            seconds <= 6'd0;
            if (seconds >= 6'd30) begin
                minutes <= sixty_next(minutes);
                if (minutes == 6'd59) hours <= hour_next(hours);
            end
        end else if (blank_n && min_step) begin
            minutes <= sixty_next(minutes);
            seconds <= 6'd0;
        end else if (blank_n && hr_step) begin
            hours <= hour_next(hours);
        end else if (sec_tick) begin
            seconds <= sixty_next(seconds);
            if (seconds == 6'd59) begin
                minutes <= sixty_next(minutes);
                if (minutes == 6'd59) hours <= hour_next(hours);
            end
        end
    end

endmodule

// File: rtl/twelve_hour_clock.sv
// Module: top of the 12-hour timekeeping core. Joins the time base, three
// debounced buttons and the time registers, and drives BCD digits.
// Assumes clk is the oscillator clock; rst_n is the power-on clear.
module twelve_hour_clock
    import clock_pkg::*;
#(
    parameter int OSC_DIV        = 4096,
    parameter int TICKS_PER_SEC  = 1024,
    parameter int DEBOUNCE_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_sel,
    input  logic       ext_clk,
    input  logic       blank_n,
    input  logic       hour_btn,
    input  logic       min_btn,
    input  logic       corr_btn,
    output logic       hr_tens,
    output logic [3:0] hr_units,
    output logic [2:0] min_tens,
    output logic [3:0] min_units,
    output logic       one_hz,
    output logic       base_out
);
    localparam int HOLD_TICKS = TICKS_PER_SEC;
    localparam int REP_TICKS  = TICKS_PER_SEC / 2;

    logic   base_tick;
    logic   sec_tick;
    logic   min_step;
    logic   hr_step;
    logic   corr_step;
    hour_t  hours_q;
    sixty_t minutes_q;
    sixty_t seconds_q;

    clock_timebase #(.DIV(OSC_DIV), .TPS(TICKS_PER_SEC)) u_base (
        .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .ext_clk(ext_clk),
        .base_tick(base_tick), .base_level(base_out),
        .sec_tick(sec_tick), .one_hz(one_hz)
    );

    clock_button #(.DEB(DEBOUNCE_TICKS), .HOLD(HOLD_TICKS), .REP(REP_TICKS),
                   .REPEAT_EN(1)) u_min_btn (
        .clk(clk), .rst_n(rst_n), .tick(base_tick), .raw(min_btn), .step(min_step)
    );

    clock_button #(.DEB(DEBOUNCE_TICKS), .HOLD(HOLD_TICKS), .REP(REP_TICKS),
                   .REPEAT_EN(1)) u_hr_btn (
        .clk(clk), .rst_n(rst_n), .tick(base_tick), .raw(hour_btn), .step(hr_step)
    );

    clock_button #(.DEB(DEBOUNCE_TICKS), .HOLD(HOLD_TICKS), .REP(REP_TICKS),
                   .REPEAT_EN(0)) u_corr_btn (
        .clk(clk), .rst_n(rst_n), .tick(base_tick), .raw(corr_btn), .step(corr_step)
    );

    clock_counter u_time (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .blank_n(blank_n),
        .corr_step(corr_step), .min_step(min_step), .hr_step(hr_step),
        .hours(hours_q), .minutes(minutes_q), .seconds(seconds_q)
    );

    // Binary to BCD digit split for the display decoder.
    always_comb begin
        hr_tens   = (hours_q >= 4'd10);
        hr_units  = hr_tens ? hours_q - 4'd10 : hours_q;
        min_tens  = 3'(minutes_q / 6'd10);
        min_units = 4'(minutes_q % 6'd10);
    end

endmodule

// File: rtl/twelve_hour_clock_chk.sv
// Checker: temporal properties of the time registers and button gating,
// bound into every twelve_hour_clock instance.
module twelve_hour_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       blank_n,
    input logic       sec_tick,
    input logic       min_step,
    input logic       hr_step,
    input logic       corr_step,
    input logic [3:0] hours,
    input logic [5:0] minutes,
    input logic [5:0] seconds,
    input logic [2:0] min_tens,
    input logic [3:0] min_units
);

    assert_hours_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hours >= 4'd1) && (hours <= 4'd12));

    assert_bcd_digits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (min_units <= 4'd9) && (min_tens <= 3'd5));

    assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hours == 4'd12 && minutes == 6'd59 && seconds == 6'd59 && sec_tick &&
         !(blank_n && (corr_step || min_step || hr_step)))
        |=> (hours == 4'd1) && (minutes == 6'd0));

    assert_min_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && min_step && !corr_step)
        |=> (minutes == (($past(minutes) == 6'd59) ? 6'd0 : $past(minutes) + 6'd1))
            && (seconds == 6'd0) && $stable(hours));

    assert_hour_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && hr_step && !min_step && !corr_step)
        |=> (hours == (($past(hours) == 4'd12) ? 4'd1 : $past(hours) + 4'd1))
            && $stable(minutes));

    assert_round_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && corr_step && seconds < 6'd30)
        |=> (seconds == 6'd0) && $stable(minutes) && $stable(hours));

    assert_blank_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_n && !sec_tick)
        |=> $stable(minutes) && $stable(hours) && $stable(seconds));

endmodule

bind twelve_hour_clock twelve_hour_clock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .sec_tick(sec_tick),
    .min_step(min_step), .hr_step(hr_step), .corr_step(corr_step),
    .hours(hours_q), .minutes(minutes_q), .seconds(seconds_q),
    .min_tens(min_tens), .min_units(min_units)
);

// File: tb/twelve_hour_clock_test.sv
// Bench: a small configuration (2 clocks per base tick, 8 ticks per second,
// 2-tick debounce); expected values are derived from the edge count.
module twelve_hour_clock_test;
    localparam int DIV = 2;
    localparam int TPS = 8;
    localparam int DEB = 2;
    localparam int CPS = DIV * TPS;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, ext_sel = 1'b0, ext_clk = 1'b0, blank_n = 1'b1;
    logic hour_btn = 1'b0, min_btn = 1'b0, corr_btn = 1'b0;
    logic hr_tens, one_hz, base_out;
    logic [3:0] hr_units, min_units;
    logic [2:0] min_tens;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    twelve_hour_clock #(.OSC_DIV(DIV), .TICKS_PER_SEC(TPS), .DEBOUNCE_TICKS(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .ext_clk(ext_clk),
        .blank_n(blank_n), .hour_btn(hour_btn), .min_btn(min_btn),
        .corr_btn(corr_btn), .hr_tens(hr_tens), .hr_units(hr_units),
        .min_tens(min_tens), .min_units(min_units), .one_hz(one_hz),
        .base_out(base_out)
    );

    function automatic int hrs_now();
        return int'(hr_tens) * 10 + int'(hr_units);
    endfunction

    function automatic int mins_now();
        return int'(min_tens) * 10 + int'(min_units);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_time(input string req, input int h, input int m);
        check({req, " hours"}, hrs_now(), h);
        check({req, " minutes"}, mins_now(), m);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // which: 0 minute, 1 hour, 2 correction; hold cycles high, then 16 low
    task automatic press(input int which, input int hold);
        case (which)
            0: min_btn = 1'b1;
            1: hour_btn = 1'b1;
            default: corr_btn = 1'b1;
        endcase
        step(hold);
        min_btn = 1'b0; hour_btn = 1'b0; corr_btn = 1'b0;
        step(24 - hold);
    endtask

    task automatic start(input logic sel);
        rst_n = 1'b0; ext_sel = sel; ext_clk = 1'b0; blank_n = 1'b1;
        min_btn = 1'b0; hour_btn = 1'b0; corr_btn = 1'b0;
        step(4);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        start(1'b0);
        rst_n = 1'b0;
        check_time("R1 reset", 12, 0);
        check("R1 reset hr_tens", int'(hr_tens), 1);
        check("R1 reset one_hz", int'(one_hz), 1);
        rst_n = 1'b1;

        // R2/R4/R5: free run through 61 minutes, every cycle against the model
        for (int e = 1; e <= 61 * 60 * CPS; e++) begin
            int sec, h, m;
            step(1);
            sec = e / CPS;
            m = (sec / 60) % 60;
            h = ((11 + sec / 3600) % 12) + 1;
            check("R4 run hours", hrs_now(), h);
            check("R4 run minutes", mins_now(), m);
            check("R5 colon", int'(one_hz), ((e / DIV) % TPS) < (TPS / 2) ? 1 : 0);
            check("R2 base_out", int'(base_out), e % DIV);
        end

        // R6: minute steps wrap without hour carry
        start(1'b0);
        for (int i = 1; i <= 60; i++) begin
            press(0, 8);
            check_time("R6 minute step", 12, i % 60);
        end
        // R7: hour steps cycle 1..12, minutes untouched
        for (int i = 1; i <= 12; i++) begin
            press(1, 8);
            check_time("R7 hour step", ((11 + i) % 12) + 1, 0);
        end
        // R8: a one-tick press is rejected
        press(0, 2);
        check_time("R8 short press", 12, 0);
        step(240);
        // R12: blanked buttons (seconds now >= 30, so correction would act)
        blank_n = 1'b0;
        press(0, 8);
        press(1, 8);
        press(2, 8);
        check_time("R12 blank lockout", 12, 0);
        blank_n = 1'b1;
        press(0, 8);
        check_time("R6 after unblank", 12, 1);

        // R10: round down clears seconds
        step(20 * CPS);
        press(2, 8);
        check_time("R10 round down", 12, 1);
        step(45 * CPS);
        check_time("R10 seconds cleared", 12, 1);
        step(20 * CPS);
        check_time("R10 later rollover", 12, 2);
        // R11: round up
        step(40 * CPS);
        press(2, 8);
        check_time("R11 round up", 12, 3);

        // R11/R4: round up carries 11:59 into 12:00
        for (int i = 0; i < 56; i++) press(0, 8);
        for (int i = 0; i < 11; i++) press(1, 8);
        check_time("R7 set 11:59", 11, 59);
        step(20 * CPS);
        press(2, 8);
        check_time("R11 carry into hour", 12, 0);
        check("R4 BCD units of 12", int'(hr_units), 2);

        // R9: auto-repeat spacing while the minute button is held
        begin
            int n, last;
            int t[3];
            n = 0; last = mins_now(); t = '{0, 0, 0};
            min_btn = 1'b1;
            for (int c = 0; c < 80; c++) begin
                step(1);
                if (mins_now() != last) begin
                    if (n < 3) t[n] = c;
                    n++;
                    last = mins_now();
                end
            end
            min_btn = 1'b0;
            step(24);
            check("R9 at least three steps", (n >= 3) ? 1 : 0, 1);
            check("R9 first repeat gap", t[1] - t[0], TPS * DIV);
            check("R9 next repeat gap", t[2] - t[1], (TPS / 2) * DIV);
        end

        // R3: external time base
        start(1'b1);
        begin
            logic vm1, vm2;
            vm1 = 1'b0; vm2 = 1'b0;
            for (int e = 1; e <= 3100; e++) begin
                logic v;
                step(1);
                check("R3 base_out follows ext", int'(base_out), int'(vm2));
                if (e == 2800) check_time("R3 before one minute", 12, 0);
                if (e == 3050) check_time("R3 after one minute", 12, 1);
                v = ((e % 6) < 3);
                ext_clk = v;
                vm2 = vm1;
                vm1 = v;
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule